// File: doc/BRIEF.md
# Two-Point ADC Calibration Engine

This block turns raw 10-bit converter codes into engineering units (millivolts, or the scaled temperature unit) for three measurement groups: main charger voltage, battery temperature and battery voltage. Factory trim is supplied as seven packed 8-bit words. Each word arrives on a load port together with a flag that says whether that word was read correctly. A start pulse makes the engine unpack each group's high and low calibration codes. From the fixed injected reference voltages it then derives a fixed-point gain and offset for each group, using a scale of 1000 and one shared restoring divider. Done pulses once all three groups have been computed.

A conversion request carries a group select and a raw code, and is answered with an acknowledge pulse and a signed result. A group that has a valid calibration is converted as `(raw × gain + offset) / 1000`. The engine runs that division iteratively and truncates toward zero. A group whose trim is missing or degenerate has a gain of zero and falls back to linear interpolation over its full-scale range. That path answers in a single cycle.

Top module: `adc_cal_engine`

## Requirements
- R1: After reset, busy, done and cv_ack are low, and every group's gain and offset are zero, so any conversion uses interpolation until a calibration run completes.
- R2: The main-voltage high code is {word0[1:0], word1[5:0], word2[7:6]} (MSB first), and its low code is word2[5:1]. The other bits of words 0 and 1 have no effect.
- R3: The temperature high code is {word2[0], word3[7:0], word4[7]}, and its low code is word4[6:2].
- R4: The battery-voltage high code is {word4[1:0], word5[7:0]}, and its low code is word6[7:2]. Bits word6[1:0] have no effect.
- R5: The reference points, as (high mV, low mV), are (19500, 315) for group 0 (main voltage), (1300, 21) for group 1 (temperature) and (4700, 2380) for group 2 (battery voltage). gain = 1000·(Vhigh−Vlow)/(codeHigh−codeLow), truncated toward zero, and offset = 1000·Vhigh − gain·codeHigh.
- R6: A group needs words 0–2 (group 0), words 2–4 (group 1) or words 4–6 (group 2). If any of its words was last loaded with ld_ok low, or was never loaded, that group's gain is zero after the run.
- R7: A group whose high code equals its low code gets gain zero, and no division is attempted for it.
- R8: A calibrated group (gain non-zero) returns (raw·gain + offset)/1000, truncated toward zero (negative results included), with one cv_ack pulse.
- R9: A group with zero gain returns min + (span·raw)/1024, truncated, with cv_ack in the cycle after the request. The ranges are 0..20030 for group 0, 0..1350 for group 1 and 2300..4800 for group 2.
- R10: After start, busy stays high until done, and done is high for exactly one cycle. A start while busy is ignored.
- R11: Load strobes while busy is high are ignored: neither the word nor its valid flag changes.
- R12: Group select 3 returns a result of 0, with cv_ack in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load strobe for one trim word |
| ld_idx | input | 3 | Index of the word being loaded (0..6) |
| ld_data | input | 8 | Trim word value |
| ld_ok | input | 1 | Word was read correctly |
| start | input | 1 | Start coefficient computation |
| busy | output | 1 | Coefficient computation in progress |
| done | output | 1 | One-cycle pulse when all groups are computed |
| cv_req | input | 1 | Conversion request |
| cv_grp | input | 2 | Group select: 0 main voltage, 1 temperature, 2 battery voltage |
| cv_raw | input | 10 | Raw ADC code |
| cv_ack | output | 1 | One-cycle pulse, result valid |
| cv_result | output | RES_W | Signed converted value |

## Verification
A corrupted unpacking field or a wrong reference constant shows up only at the first calibrated conversion of the affected group. The result then differs from the bench's own gain and offset arithmetic, usually by many units. The bench therefore converts the codes near both calibration points for every group after each run. A divider or sign error shows up in the same way, as a wrong magnitude or sign on the negative-slope case once the acknowledge arrives. A stuck group-valid or stuck FSM shows up within a few cycles: interpolation is answered one cycle late, or done arrives twice or never within the expected window.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
package adc_cal_pkg;
   localparam int NGRP   = 3;
   localparam int NWORD  = 7;
   localparam int CODE_W = 10;
   localparam int SCALE  = 1000;
   localparam int INTERP_SHIFT = 10;

   typedef enum logic [1:0] {
      GRP_VMAIN = 2'd0,
      GRP_TEMP  = 2'd1,
      GRP_VBAT  = 2'd2,
      GRP_NONE  = 2'd3
   } grp_e;

   function automatic int ref_hi_mv(input int g);
      case (g)
         0:       return 19500;
         1:       return 1300;
         default: return 4700;
      endcase
   endfunction

   function automatic int ref_lo_mv(input int g);
      case (g)
         0:       return 315;
         1:       return 21;
         default: return 2380;
      endcase
   endfunction

   function automatic int range_min(input int g);
      return (g == 2) ? 2300 : 0;
   endfunction

   function automatic int range_span(input int g);
      case (g)
         0:       return 20030;
         1:       return 1350;
         default: return 2500;
      endcase
   endfunction
endpackage

// File: rtl/adc_cal_div.sv
`timescale 1ns/1ps
module adc_cal_div #(
   parameter int DW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [DW-1:0] quot,
   output logic          fin
);
   localparam int CW = $clog2(DW + 1);

   logic [DW-1:0] q_r, d_r, r_r;
   logic [CW-1:0] cnt;
   logic          run;
   logic [DW:0]   trial, sub_t;

   assign trial = {r_r, q_r[DW-1]};
   assign sub_t = trial - {1'b0, d_r};
   assign quot  = q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0; d_r <= '0; r_r <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go && !run) begin
            q_r <= num;
            d_r <= den;
            r_r <= '0;
            cnt <= CW'(DW);
            run <= 1'b1;
         end else if (run) begin
            if (trial >= {1'b0, d_r}) begin
               r_r <= sub_t[DW-1:0];
               q_r <= {q_r[DW-2:0], 1'b1};
            end else begin
               r_r <= trial[DW-1:0];
               q_r <= {q_r[DW-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   // R7: callers never hand a zero divisor to the divider
   assert_div_den_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !run) |-> (den != '0));
   // R5: the remainder left at the end of a division is below the divisor
   assert_div_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (r_r < d_r));
endmodule

// File: rtl/adc_cal_unpack.sv
`timescale 1ns/1ps
module adc_cal_unpack
   import adc_cal_pkg::*;
(
   input  logic [NWORD-1:0][7:0]       words,
   input  logic [NWORD-1:0]            wok,
   output logic [NGRP-1:0][CODE_W-1:0] hi,
   output logic [NGRP-1:0][CODE_W-1:0] lo,
   output logic [NGRP-1:0]             grp_ok
);
   logic unused_bits;
   assign unused_bits = ^{words[0][7:2], words[1][7:6], words[6][1:0]};

   // R2: main voltage
   assign hi[0] = {words[0][1:0], words[1][5:0], words[2][7:6]};
   assign lo[0] = CODE_W'(words[2][5:1]);
   // R3: temperature
   assign hi[1] = {words[2][0], words[3], words[4][7]};
   assign lo[1] = CODE_W'(words[4][6:2]);
   // R4: battery voltage
   assign hi[2] = {words[4][1:0], words[5]};
   assign lo[2] = CODE_W'(words[6][7:2]);

   // R6: each group needs three consecutive words, neighbours share one
   genvar g;
   generate
      for (g = 0; g < NGRP; g++) begin : g_ok
         assign grp_ok[g] = &wok[2*g +: 3];
      end
   endgenerate
endmodule

// File: rtl/adc_cal_coef.sv
`timescale 1ns/1ps
module adc_cal_coef
   import adc_cal_pkg::*;
#(
   parameter int ACC_W = 48
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [NGRP-1:0][CODE_W-1:0] hi,
   input  logic [NGRP-1:0][CODE_W-1:0] lo,
   input  logic [NGRP-1:0]            grp_ok,
   output logic                       busy,
   output logic                       done,
   output logic [NGRP-1:0][ACC_W-1:0] gain,
   output logic [NGRP-1:0][ACC_W-1:0] offs
);
   typedef enum logic [1:0] {C_IDLE, C_SETUP, C_WAIT} cst_e;

   cst_e                     st;
   logic [1:0]               g;
   logic                     neg;
   logic signed [CODE_W:0]   dcode;
   logic [ACC_W-1:0]         dmag, dnum, quot;
   logic signed [ACC_W-1:0]  gq, vh_s, off_n;
   logic                     div_go, div_fin;

   assign dcode  = $signed({1'b0, hi[g]}) - $signed({1'b0, lo[g]});
   assign dmag   = dcode[CODE_W] ? ACC_W'(-dcode) : ACC_W'(dcode);
   assign dnum   = ACC_W'(longint'(SCALE) * (ref_hi_mv(int'(g)) - ref_lo_mv(int'(g))));
   assign vh_s   = ACC_W'(longint'(SCALE) * ref_hi_mv(int'(g)));
   assign gq     = neg ? -$signed(quot) : $signed(quot);
   assign off_n  = vh_s - gq * $signed({{(ACC_W-CODE_W){1'b0}}, hi[g]});
   assign div_go = (st == C_SETUP) && grp_ok[g] && (dcode != '0);
   assign busy   = (st != C_IDLE);

   adc_cal_div #(.DW(ACC_W)) i_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(dnum), .den(dmag),
      .quot(quot), .fin(div_fin));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= C_IDLE; g <= '0; neg <= 1'b0; done <= 1'b0;
         gain <= '0; offs <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            C_IDLE: if (start) begin
               g  <= '0;
               st <= C_SETUP;
            end
            C_SETUP: begin
               if (div_go) begin
                  neg <= dcode[CODE_W];
                  st  <= C_WAIT;
               end else begin
                  gain[g] <= '0;
                  offs[g] <= '0;
                  if (g == 2'(NGRP-1)) begin done <= 1'b1; st <= C_IDLE; end
                  else g <= g + 1'b1;
               end
            end
            C_WAIT: if (div_fin) begin
               gain[g] <= gq;
               offs[g] <= off_n;
               if (g == 2'(NGRP-1)) begin done <= 1'b1; st <= C_IDLE; end
               else begin g <= g + 1'b1; st <= C_SETUP; end
            end
            default: st <= C_IDLE;
         endcase
      end
   end

   // R10: done never lasts more than one cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/adc_cal_convert.sv
`timescale 1ns/1ps
module adc_cal_convert
   import adc_cal_pkg::*;
#(
   parameter int ACC_W = 48,
   parameter int RES_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req,
   input  logic [1:0]                  grp,
   input  logic [CODE_W-1:0]           raw,
   input  logic [NGRP-1:0][ACC_W-1:0]  gain,
   input  logic [NGRP-1:0][ACC_W-1:0]  offs,
   output logic                        ack,
   output logic signed [RES_W-1:0]     result
);
   typedef enum logic {V_IDLE, V_DIV} vst_e;

   vst_e                    st;
   logic [1:0]              gs;
   logic                    neg, div_go, div_fin, uncal;
   logic signed [ACC_W-1:0] acc;
   logic [ACC_W-1:0]        amag, quot;
   int                      interp;

   assign gs     = (grp == GRP_NONE) ? 2'd0 : grp;
   assign uncal  = (gain[gs] == '0);
   assign acc    = $signed({{(ACC_W-CODE_W){1'b0}}, raw}) * $signed(gain[gs]) + $signed(offs[gs]);
   assign amag   = acc[ACC_W-1] ? ACC_W'(-acc) : ACC_W'(acc);
   assign interp = range_min(int'(gs)) + ((range_span(int'(gs)) * int'(raw)) >>> INTERP_SHIFT);
   assign div_go = (st == V_IDLE) && req && (grp != GRP_NONE) && !uncal;

   adc_cal_div #(.DW(ACC_W)) i_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(amag), .den(ACC_W'(SCALE)),
      .quot(quot), .fin(div_fin));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= V_IDLE; neg <= 1'b0; ack <= 1'b0; result <= '0;
      end else begin
         ack <= 1'b0;
         case (st)
            V_IDLE: if (req) begin
               if (grp == GRP_NONE) begin
                  result <= '0;
                  ack    <= 1'b1;
               end else if (uncal) begin
                  result <= RES_W'(interp);
                  ack    <= 1'b1;
               end else begin
                  neg <= acc[ACC_W-1];
                  st  <= V_DIV;
               end
            end
            V_DIV: if (div_fin) begin
               result <= neg ? RES_W'(-$signed(quot)) : RES_W'(quot);
               ack    <= 1'b1;
               st     <= V_IDLE;
            end
            default: st <= V_IDLE;
         endcase
      end
   end

   // R9: the interpolation path answers in the next cycle
   assert_fast_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == V_IDLE && req && grp != GRP_NONE && uncal) |=> ack);
   // R8: each answer is a single-cycle pulse
   assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
endmodule

// File: rtl/adc_cal_engine.sv
`timescale 1ns/1ps
module adc_cal_engine
   import adc_cal_pkg::*;
#(
   parameter int ACC_W = 48,
   parameter int RES_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_en,
   input  logic [2:0]              ld_idx,
   input  logic [7:0]              ld_data,
   input  logic                    ld_ok,
   input  logic                    start,
   output logic                    busy,
   output logic                    done,
   input  logic                    cv_req,
   input  logic [1:0]              cv_grp,
   input  logic [9:0]              cv_raw,
   output logic                    cv_ack,
   output logic signed [RES_W-1:0] cv_result
);
   generate
      if (ACC_W < 40) begin : g_acc_chk
         $error("ACC_W must be at least 40");
      end
      if (RES_W < 16) begin : g_res_chk
         $error("RES_W must be at least 16");
      end
   endgenerate

   logic [NWORD-1:0][7:0]       words;
   logic [NWORD-1:0]            wok;
   logic [NGRP-1:0][CODE_W-1:0] hi, lo;
   logic [NGRP-1:0]             grp_ok;
   logic [NGRP-1:0][ACC_W-1:0]  gain, offs;

   // R11: trim store frozen while coefficients are being computed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
         wok   <= '0;
      end else if (ld_en && !busy && (ld_idx < 3'(NWORD))) begin
         words[ld_idx] <= ld_data;
         wok[ld_idx]   <= ld_ok;
      end
   end

   adc_cal_unpack i_unpack (
      .words(words), .wok(wok), .hi(hi), .lo(lo), .grp_ok(grp_ok));

   adc_cal_coef #(.ACC_W(ACC_W)) i_coef (
      .clk(clk), .rst_n(rst_n), .start(start), .hi(hi), .lo(lo), .grp_ok(grp_ok),
      .busy(busy), .done(done), .gain(gain), .offs(offs));

   adc_cal_convert #(.ACC_W(ACC_W), .RES_W(RES_W)) i_conv (
      .clk(clk), .rst_n(rst_n), .req(cv_req), .grp(cv_grp), .raw(cv_raw),
      .gain(gain), .offs(offs), .ack(cv_ack), .result(cv_result));

   genvar gi;
   generate
      for (gi = 0; gi < NGRP; gi++) begin : g_chk
         // R6: a group missing a trim word ends the run uncalibrated
         assert_fallback_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !grp_ok[gi]) |-> (gain[gi] == '0));
      end
   endgenerate
endmodule

// File: tb/test_adc_cal_engine.sv
`timescale 1ns/1ps
module test_adc_cal_engine;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ld_en = 0, ld_ok = 0, start = 0, cv_req = 0;
   logic [2:0] ld_idx = 0;
   logic [7:0] ld_data = 0;
   logic [1:0] cv_grp = 0;
   logic [9:0] cv_raw = 0;
   logic busy, done, cv_ack;
   logic signed [31:0] cv_result;

   int n_tests = 0, n_fail = 0;
   longint bhi[3], blo[3];
   bit     bok[3];
   longint vhm[3] = '{19500, 1300, 4700};
   longint vlm[3] = '{315, 21, 2380};
   longint rmin[3] = '{0, 0, 2300};
   longint rspan[3] = '{20030, 1350, 2500};

   always #4 clk = ~clk;

   adc_cal_engine i_adc_cal_engine (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .ld_ok(ld_ok), .start(start), .busy(busy), .done(done), .cv_req(cv_req),
      .cv_grp(cv_grp), .cv_raw(cv_raw), .cv_ack(cv_ack), .cv_result(cv_result));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint model(input int g, input longint raw);
      longint gn, of;
      if (g == 3) return 0;
      if (!bok[g] || bhi[g] == blo[g]) return rmin[g] + (rspan[g] * raw) / 1024;
      gn = (1000 * (vhm[g] - vlm[g])) / (bhi[g] - blo[g]);
      of = 1000 * vhm[g] - gn * bhi[g];
      return (raw * gn + of) / 1000;
   endfunction

   task automatic load_word(input int idx, input logic [7:0] d, input logic ok);
      @(negedge clk);
      ld_en = 1; ld_idx = 3'(idx); ld_data = d; ld_ok = ok;
      @(negedge clk);
      ld_en = 0;
   endtask

   // unused bits filled with ones so field masking is exercised (R2, R4)
   task automatic load_set(input logic [9:0] vh, input logic [4:0] vl, input logic [9:0] th,
                           input logic [4:0] tl, input logic [9:0] bh, input logic [5:0] bl,
                           input logic [6:0] okm);
      logic [7:0] w[7];
      w[0] = {6'b111111, vh[9:8]};
      w[1] = {2'b11, vh[7:2]};
      w[2] = {vh[1:0], vl, th[9]};
      w[3] = th[8:1];
      w[4] = {th[0], tl, bh[9:8]};
      w[5] = bh[7:0];
      w[6] = {bl, 2'b11};
      for (int i = 0; i < 7; i++) load_word(i, w[i], okm[i]);
      bhi[0] = vh; blo[0] = vl; bhi[1] = th; blo[1] = tl; bhi[2] = bh; blo[2] = bl;
      bok[0] = &okm[2:0]; bok[1] = &okm[4:2]; bok[2] = &okm[6:4];
   endtask

   task automatic convert(input int g, input int raw, output longint res, output int lat);
      @(negedge clk);
      cv_req = 1; cv_grp = 2'(g); cv_raw = 10'(raw);
      @(negedge clk);
      cv_req = 0;
      lat = 1;
      while (!cv_ack && lat < 300) begin @(negedge clk); lat++; end
      res = longint'(cv_result);
   endtask

   task automatic conv_chk(input string tag, input int g, input int raw);
      longint r; int lat;
      convert(g, raw, r, lat);
      chk(tag, r, model(g, raw));
   endtask

   task automatic run_cal(input string tag);
      int ndone = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk({tag, " R10 busy after start"}, busy, 1);
      repeat (5) @(negedge clk);
      start = 1;                       // ignored while busy (R10)
      @(negedge clk); start = 0;
      ld_en = 1; ld_idx = 3'd5; ld_data = 8'h00; ld_ok = 0;   // ignored (R11)
      @(negedge clk); ld_en = 0;
      for (int c = 0; c < 400; c++) begin
         if (done) ndone++;
         @(negedge clk);
      end
      chk({tag, " R10 single done pulse"}, ndone, 1);
      chk({tag, " R10 busy low after done"}, busy, 0);
   endtask

   task automatic t_reset();
      longint r; int lat;
      chk("R1 busy at reset", busy, 0);
      chk("R1 done at reset", done, 0);
      chk("R1 ack at reset", cv_ack, 0);
      convert(0, 512, r, lat);
      chk("R1 R9 interp before calibration", r, 10015);
      chk("R9 interp latency", lat, 1);
   endtask

   task automatic t_interp();
      longint r; int lat;
      load_set(10'd997, 5'd16, 10'd985, 5'd16, 10'd982, 6'd33, 7'b0000000);
      run_cal("uncal");
      convert(1, 1023, r, lat); chk("R9 temp full scale", r, 1348);
      convert(2, 0, r, lat);    chk("R9 vbat zero", r, 2300);
      convert(2, 1023, r, lat); chk("R9 vbat full scale", r, 4797);
      convert(3, 700, r, lat);  chk("R12 unused group value", r, 0);
      chk("R12 unused group latency", lat, 1);
   endtask

   task automatic t_ideal();
      load_set(10'd997, 5'd16, 10'd985, 5'd16, 10'd982, 6'd33, 7'b1111111);
      run_cal("ideal");
      conv_chk("R2 R5 R8 vmain at high code", 0, 997);
      conv_chk("R2 R5 R8 vmain at low code", 0, 16);
      conv_chk("R3 R5 R8 temp at high code", 1, 985);
      conv_chk("R3 R5 R8 temp at low code", 1, 16);
      conv_chk("R4 R5 R8 vbat at high code", 2, 982);
      conv_chk("R4 R5 R8 vbat at low code", 2, 33);
      conv_chk("R8 vbat mid", 2, 500);
   endtask

   task automatic t_odd_codes();
      load_set(10'd700, 5'd31, 10'd10, 5'd30, 10'd513, 6'd63, 7'b1111111);
      run_cal("odd");
      conv_chk("R2 R8 vmain odd codes", 0, 300);
      conv_chk("R3 R8 temp negative slope", 1, 100);
      chk("R8 negative truncation", model(1, 100), -4455);
      conv_chk("R4 R8 vbat odd codes", 2, 1000);
   endtask

   task automatic t_equal();
      load_set(10'd16, 5'd16, 10'd985, 5'd16, 10'd982, 6'd33, 7'b1111111);
      run_cal("equal");
      conv_chk("R7 equal codes interpolate", 0, 512);
      conv_chk("R7 other groups calibrated", 1, 400);
   endtask

   task automatic t_missing();
      load_set(10'd997, 5'd16, 10'd985, 5'd16, 10'd982, 6'd33, 7'b1011111);
      run_cal("missing5");
      conv_chk("R6 vbat falls back", 2, 600);
      conv_chk("R6 temp stays calibrated", 1, 600);
      load_set(10'd997, 5'd16, 10'd985, 5'd16, 10'd982, 6'd33, 7'b1101111);
      run_cal("missing4");
      conv_chk("R6 temp falls back", 1, 600);
      conv_chk("R6 vbat falls back shared word", 2, 600);
      conv_chk("R6 vmain stays calibrated", 0, 600);
   endtask

   task automatic t_busy_load();
      load_set(10'd997, 5'd16, 10'd985, 5'd16, 10'd982, 6'd33, 7'b1111111);
      run_cal("first");           // writes word 5 invalid while busy
      run_cal("second");
      conv_chk("R11 load during busy ignored", 2, 600);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_interp();
      t_ideal();
      t_odd_codes();
      t_equal();
      t_missing();
      t_busy_load();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule